// File: doc/BRIEF.md
# Bistable Spike-Driven Learning Synapse

This block is a fixed-point digital model of one plastic synapse. It holds an internal weight that stays between two bounds set by parameters. The weight moves in three ways. A presynaptic spike can step it up or down. A slow drift pulls it toward whichever bound lies on its side of a bistability threshold. Configuration inputs can force it straight to either bound.

When a spike arrives, the block looks at two values from the postsynaptic neuron, both sampled in that same cycle: a flag saying the membrane is above its threshold, and a calcium level. A step up is allowed only while calcium sits inside a potentiation window. A step down is allowed only while calcium sits inside a separate depression window. Both windows share the same lower edge, and each has its own upper edge. Outside the window that applies, the spike leaves the weight alone.

The block also produces a binary efficacy, which is the weight compared against a threshold. On every spike it emits a one-cycle current-pulse amplitude: the programmable maximum when the efficacy is high, and zero when it is low. The neuron and calcium dynamics are computed elsewhere and arrive as inputs. The thresholds, step sizes and drift rate are register inputs.

Top module: `bistable_synapse`

## Requirements
- R1: After reset the weight equals the lower bound W_LO (default 64). In a cycle with no pre_spike, no drift_tick, no force_hi and no force_lo, the weight does not change.
- R2: On a pre_spike cycle with mem_above = 1 and ca_th_lo < ca_level < ca_th_up (both comparisons strict), the weight rises by step_up on the next clock edge.
- R3: On a pre_spike cycle with mem_above = 0 and ca_th_lo < ca_level < ca_th_dn (both comparisons strict), the weight falls by step_dn on the next clock edge.
- R4: On a pre_spike cycle whose calcium lies outside the window selected by mem_above, the weight is unchanged. Calcium equal to either edge of the window counts as outside.
- R5: On a drift_tick cycle with no spike and no force, the weight moves by drift_rate. It moves toward W_HI when weight > bist_th, toward W_LO when weight < bist_th, and not at all when weight = bist_th.
- R6: Every step and every drift saturates. The weight always stays in [W_LO, W_HI] (defaults 64 and 4032) and never wraps.
- R7: A pre_spike in a cycle gives amp_vld = 1 for exactly the following cycle. In that cycle amp_out equals amp_max if the weight held during the spike cycle was greater than eff_th, and 0 otherwise. At all other times amp_vld = 0 and amp_out = 0.
- R8: force_hi sets the weight to W_HI on the next edge. force_lo alone sets it to W_LO. When both are high, force_hi wins.
- R9: Updates follow a fixed priority: force, then spike, then drift. Any pre_spike cycle takes the update slot, so a drift_tick in that same cycle has no effect.
- R10: efficacy is 1 exactly when weight > eff_th (strict). It follows the current weight and eff_th with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_spike | input | 1 | Presynaptic spike, one cycle per event |
| mem_above | input | 1 | Postsynaptic membrane above its threshold |
| ca_level | input | CA_W | Postsynaptic calcium level |
| ca_th_lo | input | CA_W | Shared lower calcium edge |
| ca_th_up | input | CA_W | Upper calcium edge for potentiation |
| ca_th_dn | input | CA_W | Upper calcium edge for depression |
| step_up | input | W_W | Potentiation step |
| step_dn | input | W_W | Depression step |
| drift_tick | input | 1 | Slow drift strobe |
| drift_rate | input | W_W | Drift amount per tick |
| bist_th | input | W_W | Bistability threshold |
| force_hi | input | 1 | Force weight to upper bound |
| force_lo | input | 1 | Force weight to lower bound |
| eff_th | input | W_W | Efficacy threshold |
| amp_max | input | AMP_W | Maximum pulse amplitude |
| weight | output | W_W | Internal weight |
| efficacy | output | 1 | Thresholded weight |
| amp_vld | output | 1 | Amplitude valid, one cycle after a spike |
| amp_out | output | AMP_W | Pulse amplitude |

## Verification
Four pairs of functions can land in the same cycle, and each pair is tested:

- Spike and drift. The bench raises pre_spike and drift_tick together. The result must equal the spike step alone, never the spike step plus the drift amount.
- Spike that causes no update and drift. A spike that leaves the weight unchanged still blocks a drift_tick in the same cycle, so the weight stays put.
- Force and spike. The bench applies a force together with a potentiating or depressing spike. The weight must land exactly on the forced bound. The amplitude emitted for that spike must still come from the weight held before the update.
- Saturation and drift or step. The bench drives steps and drift at both bounds. The results are checked against values computed in the bench.

// File: rtl/bsyn_pkg.sv
// Shared types for the bistable learning synapse.
package bsyn_pkg;

    // Outcome of the spike-time learning decision
    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_POT  = 2'd1,
        UPD_DEP  = 2'd2
    } upd_e;

endpackage

// File: rtl/bsyn_rule.sv
// Spike-time learning decision.
// Combinational. It compares the calcium level against the shared lower
// edge and against two separate upper edges, one per direction. Window
// 0 gates potentiation and window 1 gates depression. The membrane flag
// chooses which window applies. Every comparison is strict.
// Assumes the inputs are stable during the cycle in which pre_spike is high.
module bsyn_rule #(
    parameter int CA_W = 8
) (
    input  logic            mem_above,
    input  logic [CA_W-1:0] ca_level,
    input  logic [CA_W-1:0] ca_th_lo,
    input  logic [CA_W-1:0] ca_th_up,
    input  logic [CA_W-1:0] ca_th_dn,
    output bsyn_pkg::upd_e  decision
);
    import bsyn_pkg::*;

    localparam int NWIN = 2;

    logic [CA_W-1:0] hi_edge [NWIN];
    logic [NWIN-1:0] in_win;

    assign hi_edge[0] = ca_th_up;
    assign hi_edge[1] = ca_th_dn;

    // One strict window comparator per direction
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        assign in_win[g] = (ca_level > ca_th_lo) && (ca_level < hi_edge[g]);
    end

    // Choose the direction from the membrane flag, gated by its window
    always_comb begin
        decision = UPD_HOLD;
        if (mem_above) begin
            if (in_win[0]) decision = UPD_POT;
        end else begin
            if (in_win[1]) decision = UPD_DEP;
        end
    end

endmodule

// File: rtl/bsyn_satstep.sv
// Saturating step of the weight.
// Combinational. It adds (UP = 1) or subtracts (UP = 0) an amount and
// clamps the result to [W_LO, W_HI]. The arithmetic runs one bit wider
// than the weight, so a carry or a borrow is caught before any wrap.
// Assumes the incoming weight already lies inside the bounds.
module bsyn_satstep #(
    parameter int W_W  = 12,
    parameter int W_LO = 64,
    parameter int W_HI = 4032,
    parameter bit UP   = 1'b1
) (
    input  logic [W_W-1:0] w_in,
    input  logic [W_W-1:0] amount,
    output logic [W_W-1:0] w_out
);
    localparam int EXT = W_W + 1;
    localparam logic [EXT-1:0] LO_X = EXT'(W_LO);
    localparam logic [EXT-1:0] HI_X = EXT'(W_HI);

    logic [EXT-1:0] w_x;
    logic [EXT-1:0] a_x;

    assign w_x = {1'b0, w_in};
    assign a_x = {1'b0, amount};

    if (UP) begin : g_up
        logic [EXT-1:0] sum;
        // Add, then clamp at the upper bound
        always_comb begin
            sum   = w_x + a_x;
            w_out = (sum > HI_X) ? HI_X[W_W-1:0] : sum[W_W-1:0];
        end
    end else begin : g_dn
        logic [EXT-1:0] diff;
        // Subtract, then clamp at the lower bound, borrow included
        always_comb begin
            diff  = w_x - a_x;
            w_out = ((w_x < a_x) || (diff < LO_X)) ? LO_X[W_W-1:0] : diff[W_W-1:0];
        end
    end

endmodule

// File: rtl/bsyn_wreg.sv
// Weight register and update arbiter.
// Selects the next weight in priority order: force_hi, then force_lo,
// then any spike, then a drift tick. A spike cycle claims the slot even
// when its decision is HOLD. The drift direction comes from comparing
// the weight with bist_th, and a tie causes no drift.
// Assumes the candidate values have already been saturated.
module bsyn_wreg #(
    parameter int W_W  = 12,
    parameter int W_LO = 64,
    parameter int W_HI = 4032
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           force_hi,
    input  logic           force_lo,
    input  logic           spike,
    input  bsyn_pkg::upd_e decision,
    input  logic [W_W-1:0] pot_val,
    input  logic [W_W-1:0] dep_val,
    input  logic           tick,
    input  logic [W_W-1:0] bist_th,
    input  logic [W_W-1:0] drift_up_val,
    input  logic [W_W-1:0] drift_dn_val,
    output logic [W_W-1:0] weight
);
    import bsyn_pkg::*;

    localparam logic [W_W-1:0] LO_W = W_W'(W_LO);
    localparam logic [W_W-1:0] HI_W = W_W'(W_HI);

    logic [W_W-1:0] nxt;

    // Priority selection of the next weight
    always_comb begin
        nxt = weight;
        if (force_hi) begin
            nxt = HI_W;
        end else if (force_lo) begin
            nxt = LO_W;
        end else if (spike) begin
            case (decision)
                UPD_POT: nxt = pot_val;
                UPD_DEP: nxt = dep_val;
                default: nxt = weight;
            endcase
        end else if (tick) begin
            if (weight > bist_th)      nxt = drift_up_val;
            else if (weight < bist_th) nxt = drift_dn_val;
        end
    end

    // Weight state, reset to the lower bound
    always_ff @(posedge clk) begin
        if (!rst_n) weight <= LO_W;
        else        weight <= nxt;
    end

endmodule

// File: rtl/bsyn_out.sv
// Efficacy and pulse-amplitude stage.
// efficacy is a strict comparison of the weight with eff_th and is
// combinational. On a spike cycle the amplitude is registered from the
// weight held in that cycle, so the update made by the same spike does
// not affect it. It is valid for exactly one cycle.
module bsyn_out #(
    parameter int W_W   = 12,
    parameter int AMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spike,
    input  logic [W_W-1:0]   weight,
    input  logic [W_W-1:0]   eff_th,
    input  logic [AMP_W-1:0] amp_max,
    output logic             efficacy,
    output logic             amp_vld,
    output logic [AMP_W-1:0] amp_out
);
    // Hard threshold of the current weight
    assign efficacy = (weight > eff_th);

    // One-cycle amplitude pulse for each spike
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amp_vld <= 1'b0;
            amp_out <= '0;
        end else begin
            amp_vld <= spike;
            amp_out <= (spike && efficacy) ? amp_max : '0;
        end
    end

endmodule

// File: rtl/bistable_synapse.sv
// Bistable spike-driven learning synapse, top level.
// Connects the learning decision, two saturating steppers for each
// direction (one for spike steps, one for drift), the weight arbiter and
// the output stage. Bounds are parameters, and the other settings are
// register inputs that are assumed quasi-static.
module bistable_synapse #(
    parameter int W_W   = 12,
    parameter int CA_W  = 8,
    parameter int AMP_W = 8,
    parameter int W_LO  = 64,
    parameter int W_HI  = 4032
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_spike,
    input  logic             mem_above,
    input  logic [CA_W-1:0]  ca_level,
    input  logic [CA_W-1:0]  ca_th_lo,
    input  logic [CA_W-1:0]  ca_th_up,
    input  logic [CA_W-1:0]  ca_th_dn,
    input  logic [W_W-1:0]   step_up,
    input  logic [W_W-1:0]   step_dn,
    input  logic             drift_tick,
    input  logic [W_W-1:0]   drift_rate,
    input  logic [W_W-1:0]   bist_th,
    input  logic             force_hi,
    input  logic             force_lo,
    input  logic [W_W-1:0]   eff_th,
    input  logic [AMP_W-1:0] amp_max,
    output logic [W_W-1:0]   weight,
    output logic             efficacy,
    output logic             amp_vld,
    output logic [AMP_W-1:0] amp_out
);
    import bsyn_pkg::*;

    localparam int NDIR = 2;

    upd_e           decision;
    logic [W_W-1:0] spike_amt [NDIR];
    logic [W_W-1:0] spike_val [NDIR];
    logic [W_W-1:0] drift_val [NDIR];

    assign spike_amt[0] = step_up;
    assign spike_amt[1] = step_dn;

    bsyn_rule #(.CA_W(CA_W)) u_rule (
        .mem_above (mem_above),
        .ca_level  (ca_level),
        .ca_th_lo  (ca_th_lo),
        .ca_th_up  (ca_th_up),
        .ca_th_dn  (ca_th_dn),
        .decision  (decision)
    );

    // Direction 0 counts up and direction 1 counts down
    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        bsyn_satstep #(
            .W_W(W_W), .W_LO(W_LO), .W_HI(W_HI), .UP(g == 0)
        ) u_spk (
            .w_in   (weight),
            .amount (spike_amt[g]),
            .w_out  (spike_val[g])
        );
        bsyn_satstep #(
            .W_W(W_W), .W_LO(W_LO), .W_HI(W_HI), .UP(g == 0)
        ) u_drf (
            .w_in   (weight),
            .amount (drift_rate),
            .w_out  (drift_val[g])
        );
    end

    bsyn_wreg #(.W_W(W_W), .W_LO(W_LO), .W_HI(W_HI)) u_wreg (
        .clk          (clk),
        .rst_n        (rst_n),
        .force_hi     (force_hi),
        .force_lo     (force_lo),
        .spike        (pre_spike),
        .decision     (decision),
        .pot_val      (spike_val[0]),
        .dep_val      (spike_val[1]),
        .tick         (drift_tick),
        .bist_th      (bist_th),
        .drift_up_val (drift_val[0]),
        .drift_dn_val (drift_val[1]),
        .weight       (weight)
    );

    bsyn_out #(.W_W(W_W), .AMP_W(AMP_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .spike    (pre_spike),
        .weight   (weight),
        .eff_th   (eff_th),
        .amp_max  (amp_max),
        .efficacy (efficacy),
        .amp_vld  (amp_vld),
        .amp_out  (amp_out)
    );

endmodule

// File: rtl/bsyn_chk.sv
// Property checker for bistable_synapse, attached through bind.
// Sees only top-level ports.
module bsyn_chk #(
    parameter int W_W   = 12,
    parameter int CA_W  = 8,
    parameter int AMP_W = 8,
    parameter int W_LO  = 64,
    parameter int W_HI  = 4032
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pre_spike,
    input logic             mem_above,
    input logic [CA_W-1:0]  ca_level,
    input logic [CA_W-1:0]  ca_th_lo,
    input logic [CA_W-1:0]  ca_th_up,
    input logic [CA_W-1:0]  ca_th_dn,
    input logic             drift_tick,
    input logic             force_hi,
    input logic             force_lo,
    input logic [W_W-1:0]   eff_th,
    input logic [AMP_W-1:0] amp_max,
    input logic [W_W-1:0]   weight,
    input logic             amp_vld,
    input logic [AMP_W-1:0] amp_out
);
    logic no_force;
    logic win_up;
    logic win_dn;

    assign no_force = !force_hi && !force_lo;
    assign win_up   = (ca_level > ca_th_lo) && (ca_level < ca_th_up);
    assign win_dn   = (ca_level > ca_th_lo) && (ca_level < ca_th_dn);

    // R1: an idle cycle leaves the weight alone
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_spike && !drift_tick && no_force) |=> (weight == $past(weight)));

    // R2: a potentiating spike never lowers the weight
    p_pot_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_spike && no_force && mem_above && win_up) |=> (weight >= $past(weight)));

    // R3: a depressing spike never raises the weight
    p_dep_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_spike && no_force && !mem_above && win_dn) |=> (weight <= $past(weight)));

    // R4: a spike outside its window holds the weight
    p_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_spike && no_force && ((mem_above && !win_up) || (!mem_above && !win_dn)))
        |=> (weight == $past(weight)));

    // R6: the weight stays inside its bounds
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (weight >= W_W'(W_LO)) && (weight <= W_W'(W_HI)));

    // R7: a spike gives a single amplitude pulse from the weight before the update
    p_amp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_spike |=> (amp_vld && (amp_out == (($past(weight) > $past(eff_th)) ? $past(amp_max) : '0))));

    // R7: no pulse without a spike
    p_amp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_spike |=> (!amp_vld && (amp_out == '0)));

    // R8: force_hi lands on the upper bound
    p_force_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force_hi |=> (weight == W_W'(W_HI)));

    // R8: force_lo alone lands on the lower bound
    p_force_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_lo && !force_hi) |=> (weight == W_W'(W_LO)));

endmodule

bind bistable_synapse bsyn_chk #(
    .W_W(W_W), .CA_W(CA_W), .AMP_W(AMP_W), .W_LO(W_LO), .W_HI(W_HI)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pre_spike  (pre_spike),
    .mem_above  (mem_above),
    .ca_level   (ca_level),
    .ca_th_lo   (ca_th_lo),
    .ca_th_up   (ca_th_up),
    .ca_th_dn   (ca_th_dn),
    .drift_tick (drift_tick),
    .force_hi   (force_hi),
    .force_lo   (force_lo),
    .eff_th     (eff_th),
    .amp_max    (amp_max),
    .weight     (weight),
    .amp_vld    (amp_vld),
    .amp_out    (amp_out)
);

// File: tb/tb_bistable_synapse.sv
`timescale 1ns/1ps
module tb_bistable_synapse;
    localparam int W_W   = 12;
    localparam int CA_W  = 8;
    localparam int AMP_W = 8;
    localparam int W_LO  = 64;
    localparam int W_HI  = 4032;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             pre_spike, mem_above, drift_tick, force_hi, force_lo;
    logic [CA_W-1:0]  ca_level, ca_th_lo, ca_th_up, ca_th_dn;
    logic [W_W-1:0]   step_up, step_dn, drift_rate, bist_th, eff_th;
    logic [AMP_W-1:0] amp_max;
    logic [W_W-1:0]   weight;
    logic             efficacy, amp_vld;
    logic [AMP_W-1:0] amp_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bistable_synapse #(
        .W_W(W_W), .CA_W(CA_W), .AMP_W(AMP_W), .W_LO(W_LO), .W_HI(W_HI)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pre_spike(pre_spike), .mem_above(mem_above),
        .ca_level(ca_level), .ca_th_lo(ca_th_lo), .ca_th_up(ca_th_up), .ca_th_dn(ca_th_dn),
        .step_up(step_up), .step_dn(step_dn), .drift_tick(drift_tick), .drift_rate(drift_rate),
        .bist_th(bist_th), .force_hi(force_hi), .force_lo(force_lo), .eff_th(eff_th),
        .amp_max(amp_max), .weight(weight), .efficacy(efficacy), .amp_vld(amp_vld),
        .amp_out(amp_out)
    );

    // Compare one value and record the result
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge, then clear it at the next
    task automatic cyc(input logic spk, input logic mem, input int ca,
                       input logic tick, input logic fh, input logic fl);
        @(negedge clk);
        pre_spike = spk; mem_above = mem; ca_level = CA_W'(ca);
        drift_tick = tick; force_hi = fh; force_lo = fl;
        @(negedge clk);
        pre_spike = 1'b0; drift_tick = 1'b0; force_hi = 1'b0; force_lo = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset weight", int'(weight), W_LO);
        chk("R10 reset efficacy", int'(efficacy), 0);
        chk("R7 reset amp_vld", int'(amp_vld), 0);
        repeat (5) @(negedge clk);
        chk("R1 idle weight", int'(weight), W_LO);
    endtask

    task automatic t_steps();
        cyc(1, 1, 100, 0, 0, 0);
        chk("R2 potentiate", int'(weight), 164);
        chk("R7 amp valid", int'(amp_vld), 1);
        chk("R7 amp low efficacy", int'(amp_out), 0);
        @(negedge clk);
        chk("R7 amp single cycle", int'(amp_vld), 0);
        cyc(1, 0, 100, 0, 0, 0);
        chk("R3 depress", int'(weight), 84);
        cyc(1, 0, 100, 0, 0, 0);
        chk("R6 saturate low", int'(weight), W_LO);
    endtask

    task automatic t_window();
        cyc(1, 1, 20, 0, 0, 0);
        chk("R4 ca at lower edge", int'(weight), W_LO);
        cyc(1, 1, 200, 0, 0, 0);
        chk("R4 ca at up edge", int'(weight), W_LO);
        cyc(1, 0, 120, 0, 0, 0);
        chk("R4 ca at dn edge", int'(weight), W_LO);
        cyc(1, 0, 150, 0, 0, 0);
        chk("R4 depress window closed", int'(weight), W_LO);
        cyc(1, 1, 150, 0, 0, 0);
        chk("R2 wider up window", int'(weight), 164);
    endtask

    task automatic t_force();
        cyc(0, 0, 0, 0, 1, 0);
        chk("R8 force high", int'(weight), W_HI);
        chk("R10 efficacy high", int'(efficacy), 1);
        cyc(1, 1, 100, 0, 0, 0);
        chk("R6 saturate high", int'(weight), W_HI);
        chk("R7 amp full", int'(amp_out), 200);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R8 force low", int'(weight), W_LO);
        cyc(0, 0, 0, 0, 1, 1);
        chk("R8 force high wins", int'(weight), W_HI);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R8 force low again", int'(weight), W_LO);
    endtask

    task automatic t_drift();
        cyc(0, 0, 0, 1, 0, 0);
        chk("R6 drift clamp low", int'(weight), W_LO);
        bist_th = 12'd30;
        cyc(0, 0, 0, 1, 0, 0);
        chk("R5 drift up 1", int'(weight), 74);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R5 drift up 2", int'(weight), 84);
        bist_th = 12'd84;
        cyc(0, 0, 0, 1, 0, 0);
        chk("R5 drift tie", int'(weight), 84);
        bist_th = 12'd2048;
        cyc(0, 0, 0, 1, 0, 0);
        chk("R5 drift down", int'(weight), 74);
    endtask

    task automatic t_prio();
        cyc(1, 1, 100, 1, 0, 0);
        chk("R9 spike over drift", int'(weight), 174);
        cyc(1, 1, 5, 1, 0, 0);
        chk("R9 hold spike blocks drift", int'(weight), 174);
        cyc(1, 1, 100, 0, 0, 1);
        chk("R9 force over spike", int'(weight), W_LO);
        chk("R7 amp from old weight", int'(amp_out), 0);
        cyc(1, 0, 100, 0, 1, 0);
        chk("R9 force high over depress", int'(weight), W_HI);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R6 drift clamp high", int'(weight), W_HI);
        cyc(1, 0, 50, 1, 0, 0);
        chk("R9 depress over drift", int'(weight), 3952);
    endtask

    task automatic t_eff();
        cyc(0, 0, 0, 0, 0, 1);
        @(negedge clk); eff_th = 12'd64; #1;
        chk("R10 equal not above", int'(efficacy), 0);
        eff_th = 12'd63; #1;
        chk("R10 just above", int'(efficacy), 1);
        cyc(1, 0, 5, 0, 0, 0);
        chk("R4 low calcium hold", int'(weight), W_LO);
        chk("R7 amp full at threshold", int'(amp_out), 200);
        eff_th = 12'd2048;
    endtask

    initial begin
        rst_n = 1'b0; pre_spike = 1'b0; mem_above = 1'b0; drift_tick = 1'b0;
        force_hi = 1'b0; force_lo = 1'b0; ca_level = '0;
        ca_th_lo = 8'd20; ca_th_up = 8'd200; ca_th_dn = 8'd120;
        step_up = 12'd100; step_dn = 12'd80; drift_rate = 12'd10;
        bist_th = 12'd2048; eff_th = 12'd2048; amp_max = 8'd200;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_steps();
        t_window();
        t_force();
        t_drift();
        t_prio();
        t_eff();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule